// File: doc/BRIEF.md
# Two-Digit BCD Scoreboard Counter

This block keeps a decimal score between 00 and 99 for a scoreboard. It is a synchronous up/down counter that stores two BCD digits, tens and units. Each digit also drives a seven-segment pattern through a combinational decoder inside the block. Three level-sensitive button inputs control it. `inc` adds one to the score and `dec` subtracts one. `rst` asks for the score to be cleared.

A small controller has two modes: a clear mode and a counting mode. The clear mode zeroes both digits for one clock and then hands over to the counting mode. In counting mode, `rst` must stay high for five clocks in a row before the controller returns to the clear mode. A short press, or a glitch, cannot erase the score. While such a request is being qualified, the up and down buttons have no effect.

Button debouncing, display multiplexing and clock division belong to the surrounding logic.

Top module: `bcd_score_counter`

## Requirements
- R1: While `arst_n` is low, both digit outputs read 0 and both segment buses read 7'h3F. This holds at once, without waiting for a clock.
- R2: The first rising clock edge after reset is released, or after a clear has been qualified, runs the clear mode. The score stays 00 on that edge whatever `inc`, `dec` and `rst` are. Counting starts on the next edge.
- R3: In counting mode, with `rst` low, `inc`=1 and `dec`=0 raise the score by one on the next edge. When units go from 9 to 0, tens rise by one. Every digit always stays in the range 0 to 9.
- R4: In counting mode, with `rst` low, `dec`=1 and `inc`=0 lower the score by one on the next edge. When units go from 0 to 9, tens fall by one.
- R5: In counting mode, with `rst` low, the score does not change when `inc` and `dec` are equal (both 0 or both 1).
- R6: Incrementing 99 gives 00, and decrementing 00 gives 99.
- R7: Holding `rst` high for five consecutive counting-mode edges moves the controller to clear mode on the fifth edge. The score then reads 00 after the following edge.
- R8: Any edge with `rst` low restarts the qualification. Two runs of four `rst` edges split by one low edge clear nothing.
- R9: While `rst` is high in counting mode, `inc` and `dec` are ignored and the score holds.
- R10: The segment buses are active high in bit order g,f,e,d,c,b,a (bit 6 down to bit 0). Digits 0 to 9 map to 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| inc | input | 1 | Count-up button level |
| dec | input | 1 | Count-down button level |
| rst | input | 1 | Guarded clear request, level |
| tens_bcd | output | 4 | Tens digit of the score, BCD |
| units_bcd | output | 4 | Units digit of the score, BCD |
| tens_seg | output | 7 | Seven-segment pattern for the tens digit, bit 6 = g, bit 0 = a |
| units_seg | output | 7 | Seven-segment pattern for the units digit, bit 6 = g, bit 0 = a |

## Verification
- An up or down step is visible at the digit outputs one edge after the button level is applied.
- The segment buses follow the digits in the same cycle, because the decoders are combinational.
- A clear appears two edges after the fifth high `rst` edge is counted. One edge moves the controller to clear mode and the next edge zeroes the score.
- The bench drives every input on the falling edge and lets exactly one rising edge pass. It then reads the outputs on the next falling edge, so each check lands in the cycle the requirement sets. During clear qualification it checks the score after every single edge to catch an early clear or a stray count.

// File: rtl/score_pkg.sv
package score_pkg;

    localparam int unsigned BCD_W = 4;
    localparam int unsigned SEG_W = 7;

    typedef logic [BCD_W-1:0] bcd_t;
    typedef logic [SEG_W-1:0] seg_t;

    typedef enum logic {
        MODE_CLEAR = 1'b0,
        MODE_COUNT = 1'b1
    } mode_e;

endpackage

// File: rtl/bcd_digit_step.sv
module bcd_digit_step
    import score_pkg::*;
#(
    parameter int unsigned RADIX = 10
) (
    input  bcd_t cur_i,
    input  logic en_i,
    input  logic up_i,
    input  logic down_i,
    output bcd_t nxt_o,
    output logic chain_o
);
    localparam bcd_t TOP_V = BCD_W'(RADIX - 1);

    always_comb begin
        nxt_o   = cur_i;
        chain_o = 1'b0;
        if (en_i) begin
            if (up_i) begin
                if (cur_i == TOP_V) begin
                    nxt_o   = '0;
                    chain_o = 1'b1;
                end else begin
                    nxt_o = cur_i + 1'b1;
                end
            end else if (down_i) begin
                if (cur_i == '0) begin
                    nxt_o   = TOP_V;
                    chain_o = 1'b1;
                end else begin
                    nxt_o = cur_i - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/clear_guard.sv
module clear_guard #(
    parameter int unsigned HOLD_CYCLES = 5
) (
    input  logic clk,
    input  logic arst_n,
    input  logic active_i,
    input  logic rst_i,
    output logic fire_o
);
    localparam int unsigned HOLD_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [HOLD_W-1:0] LAST_V = HOLD_W'(HOLD_CYCLES - 1);

    logic [HOLD_W-1:0] hold_d, hold_q;

    always_comb begin
        fire_o = 1'b0;
        hold_d = '0;
        if (active_i && rst_i) begin
            if (hold_q == LAST_V) begin
                fire_o = 1'b1;
            end else begin
                hold_d = hold_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    // R8: a low request edge always restarts qualification
    assert_hold_restart_R8: assert property (@(posedge clk) disable iff (!arst_n)
        !rst_i |=> hold_q == '0);

    // R8: each qualifying edge advances the hold count by exactly one
    assert_hold_advance_R8: assert property (@(posedge clk) disable iff (!arst_n)
        (active_i && rst_i && hold_q != LAST_V) |=> hold_q == $past(hold_q) + 1'b1);

    // R7: the hold count never passes its final value
    assert_hold_bound_R7: assert property (@(posedge clk) disable iff (!arst_n)
        hold_q <= LAST_V);

endmodule

// File: rtl/seg7_decoder.sv
module seg7_decoder
    import score_pkg::*;
(
    input  bcd_t digit_i,
    output seg_t seg_o
);
    always_comb begin
        unique case (digit_i)
            4'd0:    seg_o = 7'h3F;
            4'd1:    seg_o = 7'h06;
            4'd2:    seg_o = 7'h5B;
            4'd3:    seg_o = 7'h4F;
            4'd4:    seg_o = 7'h66;
            4'd5:    seg_o = 7'h6D;
            4'd6:    seg_o = 7'h7D;
            4'd7:    seg_o = 7'h07;
            4'd8:    seg_o = 7'h7F;
            4'd9:    seg_o = 7'h6F;
            default: seg_o = 7'h00;
        endcase
    end

endmodule

// File: rtl/bcd_score_counter.sv
module bcd_score_counter
    import score_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 5,
    parameter int unsigned RADIX       = 10
) (
    input  logic       clk,
    input  logic       arst_n,
    input  logic       inc,
    input  logic       dec,
    input  logic       rst,
    output logic [3:0] tens_bcd,
    output logic [3:0] units_bcd,
    output logic [6:0] tens_seg,
    output logic [6:0] units_seg
);
    localparam int unsigned NUM_DIGITS = 2;
    localparam bcd_t        TOP_V      = BCD_W'(RADIX - 1);

    typedef struct packed {
        mode_e                  mode;
        bcd_t [NUM_DIGITS-1:0]  digit;
    } core_t;

    core_t core_d, core_q;

    logic                  counting;
    logic                  step_en;
    logic                  clear_fire;
    logic [NUM_DIGITS:0]   chain;
    bcd_t [NUM_DIGITS-1:0] stepped;
    seg_t [NUM_DIGITS-1:0] segs;

    assign counting = (core_q.mode == MODE_COUNT);
    assign step_en  = counting && !rst && (inc ^ dec);
    assign chain[0] = step_en;

    clear_guard #(
        .HOLD_CYCLES(HOLD_CYCLES)
    ) u_guard (
        .clk     (clk),
        .arst_n  (arst_n),
        .active_i(counting),
        .rst_i   (rst),
        .fire_o  (clear_fire)
    );

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
        bcd_digit_step #(
            .RADIX(RADIX)
        ) u_step (
            .cur_i  (core_q.digit[g]),
            .en_i   (chain[g]),
            .up_i   (inc),
            .down_i (dec),
            .nxt_o  (stepped[g]),
            .chain_o(chain[g+1])
        );

        seg7_decoder u_dec (
            .digit_i(core_q.digit[g]),
            .seg_o  (segs[g])
        );
    end

    always_comb begin
        core_d = core_q;
        unique case (core_q.mode)
            MODE_CLEAR: begin
                core_d.digit = '0;
                core_d.mode  = MODE_COUNT;
            end
            MODE_COUNT: begin
                if (clear_fire) begin
                    core_d.mode = MODE_CLEAR;
                end else if (!rst) begin
                    core_d.digit = stepped;
                end
            end
            default: core_d.mode = MODE_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            core_q.mode  <= MODE_CLEAR;
            core_q.digit <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign units_bcd = core_q.digit[0];
    assign tens_bcd  = core_q.digit[1];
    assign units_seg = segs[0];
    assign tens_seg  = segs[1];

    // R3: both digits stay inside the decimal range
    assert_digit_range_R3: assert property (@(posedge clk) disable iff (!arst_n)
        (units_bcd <= TOP_V) && (tens_bcd <= TOP_V));

    // R3: a plain up step below 9 moves units by one and leaves tens alone
    assert_inc_step_R3: assert property (@(posedge clk) disable iff (!arst_n)
        (counting && !rst && inc && !dec && units_bcd != TOP_V)
        |=> (units_bcd == $past(units_bcd) + 1'b1) && $stable(tens_bcd));

    // R4: a borrow from units decrements tens
    assert_dec_borrow_R4: assert property (@(posedge clk) disable iff (!arst_n)
        (counting && !rst && dec && !inc && units_bcd == '0 && tens_bcd != '0)
        |=> (units_bcd == TOP_V) && (tens_bcd == $past(tens_bcd) - 1'b1));

    // R5: equal buttons leave the score untouched
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!arst_n)
        (counting && !rst && inc == dec) |=> $stable(core_q.digit));

    // R6: carry out of the tens digit lands on 00
    assert_wrap_up_R6: assert property (@(posedge clk) disable iff (!arst_n)
        (counting && !rst && inc && !dec && chain[NUM_DIGITS])
        |=> (units_bcd == '0) && (tens_bcd == '0));

    // R6: stepping down from 00 lands on 99
    assert_wrap_down_R6: assert property (@(posedge clk) disable iff (!arst_n)
        (counting && !rst && dec && !inc && units_bcd == '0 && tens_bcd == '0)
        |=> (units_bcd == TOP_V) && (tens_bcd == TOP_V));

    // R7: clear mode always zeroes the score and hands back to counting
    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!arst_n)
        (core_q.mode == MODE_CLEAR)
        |=> (units_bcd == '0) && (tens_bcd == '0) && (core_q.mode == MODE_COUNT));

    // R9: a pending clear request freezes the score
    assert_rst_freeze_R9: assert property (@(posedge clk) disable iff (!arst_n)
        (counting && rst) |=> $stable(core_q.digit));

endmodule

// File: tb/bcd_score_counter_test.sv
module bcd_score_counter_test;

    logic       clk = 1'b0;
    logic       arst_n = 1'b0;
    logic       inc = 1'b0;
    logic       dec = 1'b0;
    logic       rst = 1'b0;
    logic [3:0] tens_bcd, units_bcd;
    logic [6:0] tens_seg, units_seg;

    int n_chk  = 0;
    int n_fail = 0;
    int score  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    bcd_score_counter uut (
        .clk      (clk),
        .arst_n   (arst_n),
        .inc      (inc),
        .dec      (dec),
        .rst      (rst),
        .tens_bcd (tens_bcd),
        .units_bcd(units_bcd),
        .tens_seg (tens_seg),
        .units_seg(units_seg)
    );

    function automatic int seg_of(input int d);
        case (d)
            0: return 'h3F;  1: return 'h06;  2: return 'h5B;  3: return 'h4F;
            4: return 'h66;  5: return 'h6D;  6: return 'h7D;  7: return 'h07;
            8: return 'h7F;  9: return 'h6F;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                     req, what, got, got, exp, exp);
        end
    endtask

    task automatic check_score(input string req, input int s);
        chk(req, "tens", int'(tens_bcd), s / 10);
        chk(req, "units", int'(units_bcd), s % 10);
        chk({req, "/R10"}, "tens_seg", int'(tens_seg), seg_of(s / 10));
        chk({req, "/R10"}, "units_seg", int'(units_seg), seg_of(s % 10));
    endtask

    // called at a falling edge: drive, pass one rising edge, return at the next falling edge
    task automatic step(input logic i, input logic d, input logic r);
        inc = i; dec = d; rst = r;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check_score("R1", 0);
        inc = 1'b1;
        @(negedge clk);
        arst_n = 1'b1;
        step(1, 0, 0);
        check_score("R2", 0);          // first edge runs the clear mode
        step(1, 0, 0);
        score = 1;
        check_score("R3", score);
    endtask

    task automatic t_inc_carry;
        for (int k = 0; k < 11; k++) begin
            step(1, 0, 0);
            score = (score + 1) % 100;
            check_score("R3", score);   // passes 09 -> 10
        end
    endtask

    task automatic t_dec_borrow;
        for (int k = 0; k < 3; k++) begin
            step(0, 1, 0);
            score = (score + 99) % 100;
            check_score("R4", score);   // passes 10 -> 09
        end
    endtask

    task automatic t_idle;
        step(1, 1, 0); check_score("R5", score);
        step(0, 0, 0); check_score("R5", score);
        step(1, 1, 0); check_score("R5", score);
    endtask

    task automatic t_guarded_clear;
        for (int k = 0; k < 5; k++) begin
            step(1, 0, 1);
            check_score("R9", score);   // no count, no early clear
        end
        step(1, 0, 0);
        score = 0;
        check_score("R7", score);       // clear mode ran, inc ignored (R2)
        step(1, 0, 0);
        score = 1;
        check_score("R2", score);
    endtask

    task automatic t_short_request;
        for (int k = 0; k < 4; k++) begin
            step(0, 1, 1);
            check_score("R9", score);
        end
        step(0, 0, 0);
        check_score("R8", score);
        for (int k = 0; k < 4; k++) begin
            step(1, 0, 1);
            check_score("R8", score);
        end
        step(1, 0, 0);
        score = score + 1;
        check_score("R8", score);       // no clear happened, counting continues
    endtask

    task automatic t_wrap;
        for (int k = 0; k < 5; k++) step(0, 0, 1);
        step(0, 0, 0);
        score = 0;
        check_score("R7", score);
        step(0, 1, 0);
        score = 99;
        check_score("R6", score);
        step(1, 0, 0);
        score = 0;
        check_score("R6", score);
    endtask

    task automatic t_seg_table;
        for (int k = 0; k < 10; k++) begin
            chk("R10", "units_seg", int'(units_seg), seg_of(k));
            step(1, 0, 0);
            score = score + 1;
        end
        check_score("R10", score);
    endtask

    initial begin
        t_reset();
        t_inc_carry();
        t_dec_borrow();
        t_idle();
        t_guarded_clear();
        t_short_request();
        t_wrap();
        t_seg_table();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule